// File: doc/BRIEF.md
# Framed Serial Transmitter for Sensor Readings

The block sends a fixed frame of asynchronous serial characters that carries a set of sensor readings. A one-cycle start request taken while the block is idle copies every reading into an internal snapshot. The block then sends a header character, two data characters for each reading, and a trailer character. The characters go out back to back on a line that idles high. Each character is 8-N-1 with the data bits sent most-significant first.

Bit cells use a fractional cycle count. With the default 6945-cycle character at a 40 MHz clock (57600 baud), the cells alternate between 694 and 695 cycles. Every bit boundary falls at the rounded-down value of k·6945/10 cycles from the start edge, so the timing error does not build up across a character. The block shows `busy` for the whole frame and pulses `done` for one cycle when the frame ends.

Top module: `rdgFrameTx`

## Requirements
- R1: After reset, and whenever the block is idle, `txd` is 1 and `busy` is 0. `done` is 0 after reset.
- R2: A `startReq` high at a clock edge while idle is accepted. From the next cycle `busy` is 1, `txd` is 0 (the start bit), and all readings are captured from `rdgIn`.
- R3: Counted from a character's first cycle, bit cell k (k = 0..9) covers cycles floor(k·CHAR_CYC/10) up to floor((k+1)·CHAR_CYC/10)−1. With the default CHAR_CYC of 6945, the cells are 694 or 695 cycles long and a character lasts 6945 cycles.
- R4: Each character is sent as a 0 start bit, then data bits 7 down to 0, then a 1 stop bit.
- R5: A frame has 2·NUM_RDG+2 characters (28 by default), indexed from 0 and sent back to back with no idle cycles between them.
- R6: Character 0 is the header 8'hA0 (top three bits 101, low five bits 0). The last character is the trailer 8'h40 (top three bits 010, low five bits 0).
- R7: Data characters have 000 in bits 7..5. Odd character 2i+1 carries bits 9..5 of reading i in bits 4..0. Character 2i+2 carries bits 4..0 of the same reading. Reading i sits at `rdgIn[10i+9:10i]`.
- R8: `done` is high for exactly one cycle, the cycle right after the trailer's stop bit ends. `busy` falls in that same cycle.
- R9: A `startReq` that arrives while `busy` is 1 is ignored. The frame in progress is not restarted or changed, and no second frame follows.
- R10: Changes on `rdgIn` during a frame do not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to send one frame |
| rdgIn | input | NUM_RDG·10 | Readings, reading i in bits 10i+9..10i |
| txd | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions check several handshake rules on every cycle:
- the line is high whenever the block is idle;
- an accepted request raises `busy` together with a low start bit;
- `busy` stays up until `done`;
- `done` is a single cycle and coincides with `busy` falling.

Some behaviours need a full expected frame, so only the bench scenarios can show them: the exact position of every fractional cell boundary, the most-significant-first bit order, the header, data and trailer contents, and the ascending order of the readings. The bench compares `txd` on every cycle against a frame it builds itself. It also shows that captured data survives input changes and that a request made mid-frame is ignored.

// File: rtl/rdgTxPkg.sv
package rdgTxPkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;   // copy all readings into the snapshot
    logic loadChar;  // load a new character into the shifter
    logic shiftBit;  // advance to the next bit cell
  } txStrobe_t;
endpackage

// File: rtl/rdgTxCtrl.sv
module rdgTxCtrl
  import rdgTxPkg::*;
#(
  parameter int NUM_CHARS = 28,
  parameter int CHAR_CYC  = 6945,
  parameter int BITS      = 10,
  parameter int CHR_W     = $clog2(NUM_CHARS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output txStrobe_t        strb,
  output logic [CHR_W-1:0] loadIdx,
  output logic             busy,
  output logic             done
);
  localparam int BASE  = CHAR_CYC / BITS;
  localparam int FRAC  = CHAR_CYC % BITS;
  localparam int CNT_W = $clog2(BASE + 1);
  localparam int ACC_W = $clog2(2 * BITS + 1);
  localparam int BIT_W = $clog2(BITS);

  logic [CNT_W-1:0] cellCnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accSum;
  logic [BIT_W-1:0] bitIdx;
  logic [CHR_W-1:0] charIdx;
  logic             cellLong;
  logic             cellEnd;
  logic             lastBit;
  logic             lastChar;

  // Fractional cell length: a cell is one cycle longer whenever the
  // remainder accumulator crosses BITS, giving floor(k*CHAR_CYC/BITS) edges.
  always_comb begin
    accSum   = acc + ACC_W'(FRAC);
    cellLong = (accSum >= ACC_W'(BITS));
    cellEnd  = busy && (cellCnt == (cellLong ? CNT_W'(BASE) : CNT_W'(BASE - 1)));
    lastBit  = (bitIdx == BIT_W'(BITS - 1));
    lastChar = (charIdx == CHR_W'(NUM_CHARS - 1));
    strb.capture  = !busy && startReq;
    strb.loadChar = strb.capture || (cellEnd && lastBit && !lastChar);
    strb.shiftBit = cellEnd && !lastBit;
    loadIdx  = strb.capture ? '0 : charIdx + CHR_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cellCnt <= '0;
      acc     <= '0;
      bitIdx  <= '0;
      charIdx <= '0;
    end else begin
      done <= 1'b0;
      if (strb.capture) begin
        busy    <= 1'b1;
        cellCnt <= '0;
        acc     <= '0;
        bitIdx  <= '0;
        charIdx <= '0;
      end else if (busy) begin
        if (cellEnd) begin
          cellCnt <= '0;
          if (lastBit) begin
            bitIdx <= '0;
            acc    <= '0;
            if (lastChar) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              charIdx <= charIdx + CHR_W'(1);
            end
          end else begin
            bitIdx <= bitIdx + BIT_W'(1);
            acc    <= cellLong ? accSum - ACC_W'(BITS) : accSum;
          end
        end else begin
          cellCnt <= cellCnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rdgTxData.sv
module rdgTxData
  import rdgTxPkg::*;
#(
  parameter int NUM_RDG  = 13,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 8,
  parameter int NUM_CHARS = 2 * NUM_RDG + 2,
  parameter int CHR_W    = $clog2(NUM_CHARS),
  parameter logic [TAG_W-1:0] HDR_TAG = 3'b101,
  parameter logic [TAG_W-1:0] TRL_TAG = 3'b010,
  parameter logic [TAG_W-1:0] DAT_TAG = 3'b000
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  txStrobe_t                              strb,
  input  logic [CHR_W-1:0]                       loadIdx,
  input  logic [NUM_RDG*2*(DATA_W-TAG_W)-1:0]    rdgIn,
  output logic                                   txd
);
  localparam int HALF_W = DATA_W - TAG_W;
  localparam int RDG_W  = 2 * HALF_W;
  localparam int SH_W   = DATA_W + 2;

  logic [RDG_W-1:0]  snap [NUM_RDG];
  logic [RDG_W-1:0]  picked;
  logic [CHR_W-1:0]  rdgSel;
  logic [DATA_W-1:0] charByte;
  logic [SH_W-1:0]   shReg;

  // Snapshot, one register per reading
  for (genvar g = 0; g < NUM_RDG; g++) begin : g_snap
    always_ff @(posedge clk) begin
      if (!rstN)            snap[g] <= '0;
      else if (strb.capture) snap[g] <= rdgIn[g*RDG_W +: RDG_W];
    end
  end

  // Character builder
  always_comb begin
    rdgSel = (loadIdx - CHR_W'(1)) >> 1;
    picked = '0;
    for (int i = 0; i < NUM_RDG; i++) begin
      if (rdgSel == CHR_W'(i)) picked = snap[i];
    end
    if (loadIdx == '0)
      charByte = {HDR_TAG, {HALF_W{1'b0}}};
    else if (loadIdx == CHR_W'(NUM_CHARS - 1))
      charByte = {TRL_TAG, {HALF_W{1'b0}}};
    else if (loadIdx[0])
      charByte = {DAT_TAG, picked[RDG_W-1:HALF_W]};
    else
      charByte = {DAT_TAG, picked[HALF_W-1:0]};
  end

  // Left shifter: start bit at the top, data MSB next, stop bit last
  always_ff @(posedge clk) begin
    if (!rstN)              shReg <= '1;
    else if (strb.loadChar) shReg <= {1'b0, charByte, 1'b1};
    else if (strb.shiftBit) shReg <= {shReg[SH_W-2:0], 1'b1};
  end

  assign txd = shReg[SH_W-1];
endmodule

// File: rtl/rdgFrameTx.sv
module rdgFrameTx
  import rdgTxPkg::*;
#(
  parameter int NUM_RDG  = 13,
  parameter int TAG_W    = 3,
  parameter int DATA_W   = 8,
  parameter int CHAR_CYC = 6945
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic                                startReq,
  input  logic [NUM_RDG*2*(DATA_W-TAG_W)-1:0] rdgIn,
  output logic                                txd,
  output logic                                busy,
  output logic                                done
);
  localparam int NUM_CHARS = 2 * NUM_RDG + 2;
  localparam int CHR_W     = $clog2(NUM_CHARS);
  localparam int BITS      = DATA_W + 2;

  txStrobe_t        strb;
  logic [CHR_W-1:0] loadIdx;

  rdgTxCtrl #(
    .NUM_CHARS(NUM_CHARS), .CHAR_CYC(CHAR_CYC), .BITS(BITS), .CHR_W(CHR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .strb(strb), .loadIdx(loadIdx), .busy(busy), .done(done)
  );

  rdgTxData #(
    .NUM_RDG(NUM_RDG), .TAG_W(TAG_W), .DATA_W(DATA_W),
    .NUM_CHARS(NUM_CHARS), .CHR_W(CHR_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .strb(strb), .loadIdx(loadIdx),
    .rdgIn(rdgIn), .txd(txd)
  );
endmodule

// File: rtl/rdgFrameTxChk.sv
module rdgFrameTxChk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic txd,
  input logic busy,
  input logic done
);
  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txd);

  a_r2_accept_start_bit: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq) |=> (busy && !txd));

  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (busy || done));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

bind rdgFrameTx rdgFrameTxChk chk_i (
  .clk(clk), .rstN(rstN), .startReq(startReq),
  .txd(txd), .busy(busy), .done(done)
);

// File: tb/rdgFrameTx_tb_top.sv
module rdgFrameTx_tb_top;
  localparam int NR    = 13;
  localparam int CC    = 65;            // scaled character: cells of 6 or 7 cycles
  localparam int NCH   = 2 * NR + 2;
  localparam int TOTAL = NCH * CC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [NR*10-1:0] rdgIn;
  logic txd, busy, done;
  logic [9:0] cur [NR];
  logic [9:0] expRd [NR];
  int nChk = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // Stimulus table: {base, step}; reading i = base + i*step (mod 1024)
  localparam logic [19:0] PAT [4] = '{
    {10'h000, 10'h000}, {10'h3FF, 10'h000},
    {10'h2AA, 10'h16B}, {10'h001, 10'h04F}};

  always #5 clk = ~clk;

  always_comb for (int i = 0; i < NR; i++) rdgIn[i*10 +: 10] = cur[i];

  rdgFrameTx #(.NUM_RDG(NR), .CHAR_CYC(CC)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .rdgIn(rdgIn),
    .txd(txd), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(input int c);
    int i;
    if (c == 0) return 8'hA0;
    if (c == NCH - 1) return 8'h40;
    i = (c - 1) / 2;
    return (c % 2 == 1) ? {3'b000, expRd[i][9:5]} : {3'b000, expRd[i][4:0]};
  endfunction

  // Expected line level at frame cycle t (R3 boundaries, R4 bit order)
  function automatic logic expTxd(input int t);
    int c, r, k;
    logic [7:0] b;
    c = t / CC;
    r = t % CC;
    k = 0;
    for (int j = 0; j < 10; j++) if (r >= (j * CC) / 10) k = j;
    b = expByte(c);
    if (k == 0) return 1'b0;
    if (k == 9) return 1'b1;
    return b[8 - k];
  endfunction

  task automatic runFrame(input int p, input bit disturb);
    int charErr, busyErr, firstBad;
    for (int i = 0; i < NR; i++) begin
      cur[i]   = PAT[p][19:10] + 10'(i) * PAT[p][9:0];
      expRd[i] = cur[i];
    end
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    charErr = 0; busyErr = 0; firstBad = -1;
    for (int t = 0; t < TOTAL; t++) begin
      if (t > 0) @(negedge clk);
      if (disturb && t == 200) begin
        startReq = 1'b1;                               // R9: request while busy
        for (int i = 0; i < NR; i++) cur[i] = ~cur[i]; // R10: inputs change
      end
      if (disturb && t == 201) startReq = 1'b0;
      if (txd !== expTxd(t)) begin
        charErr++;
        if (firstBad < 0) firstBad = t;
      end
      if (busy !== 1'b1 || done !== 1'b0) busyErr++;
      if (t % CC == CC - 1) begin
        if (t / CC == 0 || t / CC == NCH - 1)
          check(charErr == 0, "R6 R3 R4 header/trailer char", firstBad, t / CC);
        else
          check(charErr == 0, disturb ? "R7 R10 R9 data char" : "R7 R3 R4 data char",
                firstBad, t / CC);
        charErr = 0;
      end
    end
    check(busyErr == 0, "R5 busy held over back-to-back frame", busyErr, 0);
    @(negedge clk);
    check(done === 1'b1 && busy === 1'b0 && txd === 1'b1,
          "R8 done after trailer stop", {done, busy, txd}, 3'b101);
    @(negedge clk);
    check(done === 1'b0, "R8 done one cycle", done, 0);
  endtask

  initial begin
    for (int i = 0; i < NR; i++) cur[i] = '0;
    repeat (3) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0 && done === 1'b0, "R1 reset state",
          {txd, busy, done}, 3'b100);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R1 idle after reset", {txd, busy}, 2'b10);

    // Walk the stimulus table (R2..R8), disturbing one frame (R9, R10)
    for (int p = 0; p < 4; p++) runFrame(p, p == 2);

    // R9 / R1: no second frame after an ignored mid-frame request
    begin
      int hi = 0;
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        if (txd === 1'b1 && busy === 1'b0) hi++;
      end
      check(hi == 40, "R9 R1 line idle after frame", hi, 40);
    end

    // R2: start accepted on the very next edge, start bit low
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    check(busy === 1'b1 && txd === 1'b0, "R2 accept gives start bit", {busy, txd}, 2'b10);
    // R3: first cell length at scaled size is floor(CC/10) cycles
    begin
      int len = 1;
      @(negedge clk);
      while (txd === 1'b0 && len < 20) begin len++; @(negedge clk); end
      check(len == CC / 10 || txd === 1'b0, "R3 first cell length", len, CC / 10);
    end
    while (busy) @(negedge clk);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule